// File: doc/BRIEF.md
# UART Receive FIFO Status Controller

This block is the receive half of a UART. A serial line is oversampled sixteen times per bit, each frame is checked at mid-bit and its data byte goes into a receive FIFO. Software reaches the block through a small register port: a control register, a status register, a data register that pops the FIFO when read, and a count register that gives the number of bytes waiting.

The data-ready flag is tied to a programmable trigger level and not to single bytes. A one-cycle interrupt pulse marks the moment the flag becomes set. Parity, framing, overrun and break conditions each have a flag of their own, plus a combined receive-error flag. A flag is cleared only by a write of 0 that follows a read in which software saw that flag as 1. The live level of the serial input can be read next to the flags, so software can tell a break from an ordinary framing error.

Registers (8-bit, address on `reg_addr`): 0 = control (bit0 receive enable, bit1 even-parity enable, bits3:2 trigger select); 1 = status (bit0 data-ready, bit1 receive error, bit2 break, bit3 parity error, bit4 framing error, bit5 overrun, bit6 live serial input); 2 = receive data; 3 = fill count.

Top module: `uart_rx_status`

## Requirements
- R1: With control bit1 = 0 a frame is start, 8 data bits LSB first, stop (8N1). With bit1 = 1 an even parity bit follows the data (8E1). A start bit that is no longer low at its mid-point is discarded. Each received byte is pushed into the FIFO.
- R2: The FIFO holds 16 bytes in arrival order. A read of address 2 returns the oldest byte and removes it. Address 3 returns the fill count in bits 4:0.
- R3: A read of address 2 while the FIFO is empty returns the last byte popped and leaves the count unchanged.
- R4: A byte that arrives while 16 bytes are held is discarded, and status bit5 (overrun) is set.
- R5: Status bit0 (data-ready) sets when the count reaches the trigger level. The trigger select codes 0, 1, 2 and 3 give 1, 4, 8 and 14 bytes. Fewer bytes than the trigger level leave bit0 at 0.
- R6: `rx_irq` is high for exactly one cycle each time status bit0 goes from 0 to 1.
- R7: A status flag clears when status is written with 0 in its bit after a status read returned that bit as 1. A write of 0 without such a read leaves the flag set. Writing 1 never sets a flag.
- R8: A clear of bit0 takes effect only while the count is below the trigger level; otherwise bit0 stays 1.
- R9: In 8E1 a parity bit that does not match even parity sets status bit3 and bit1.
- R10: A stop bit sampled low sets status bit4 and bit1. The byte is still pushed.
- R11: A frame whose data, parity and stop positions are all low sets status bit2 as well as bit4, and pushes 0x00. Status bit6 reads the current level of `rxd`.
- R12: With control bit0 = 0, frames on `rxd` are not received and the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | 16x oversampling strobe |
| rxd | input | 1 | Serial input, idle high |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on address 2) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The frame path is driven with a table of frames that differ in one thing at a time: a clean 8N1 byte, a clean 8E1 byte, a wrong parity bit, a low stop bit under a non-zero byte, an all-low frame, and a null byte with a proper stop. Comparing these shows whether each error flag follows only its own cause, and whether break detection tells an all-zero line from a genuine zero byte. Directed sequences then fill the FIFO below, at and past the trigger levels 4 and 14, and up to overrun. They try the clear handshake with and without the preceding read, read from an empty FIFO, and send frames while reception is disabled.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    localparam int BYTE_W = 8;

    // status flag positions
    localparam int FL_RDY  = 0;
    localparam int FL_ERR  = 1;
    localparam int FL_BRK  = 2;
    localparam int FL_PAR  = 3;
    localparam int FL_FRM  = 4;
    localparam int FL_OVR  = 5;
    localparam int FL_NUM  = 6;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_frame_t;

endpackage

// File: rtl/rx_frame_sampler.sv
module rx_frame_sampler
    import uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rx_en,
    input  logic      par_en,
    input  logic      rxd,
    output logic      frm_valid,
    output rx_frame_t frm
);
    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [2:0]        bits;
        logic [BYTE_W-1:0] sh;
        logic              pbit;
        logic              s1;
        logic              s2;
        logic              valid;
        rx_frame_t         frm;
    } smp_t;

    smp_t smp_d, smp_q;
    logic rx_s;

    assign rx_s = smp_q.s2;

    always_comb begin
        smp_d       = smp_q;
        smp_d.valid = 1'b0;
        smp_d.s1    = rxd;
        smp_d.s2    = smp_q.s1;
        if (!rx_en) begin
            smp_d.st = RX_IDLE;
        end else if (tick) begin
            case (smp_q.st)
                RX_IDLE: begin
                    if (!rx_s) begin
                        smp_d.st  = RX_START;
                        smp_d.cnt = '0;
                    end
                end
                RX_START: begin
                    if (smp_q.cnt == MID) begin
                        smp_d.cnt  = '0;
                        smp_d.bits = '0;
                        smp_d.st   = rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        smp_d.cnt = smp_q.cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (smp_q.cnt == LAST) begin
                        smp_d.cnt = '0;
                        smp_d.sh  = {rx_s, smp_q.sh[BYTE_W-1:1]};
                        if (smp_q.bits == 3'd7) begin
                            smp_d.st = par_en ? RX_PAR : RX_STOP;
                        end else begin
                            smp_d.bits = smp_q.bits + 1'b1;
                        end
                    end else begin
                        smp_d.cnt = smp_q.cnt + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (smp_q.cnt == LAST) begin
                        smp_d.cnt  = '0;
                        smp_d.pbit = rx_s;
                        smp_d.st   = RX_STOP;
                    end else begin
                        smp_d.cnt = smp_q.cnt + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (smp_q.cnt == LAST) begin
                        smp_d.valid    = 1'b1;
                        smp_d.frm.data = smp_q.sh;
                        smp_d.frm.perr = par_en && (smp_q.pbit != ^smp_q.sh);
                        smp_d.frm.ferr = !rx_s;
                        smp_d.frm.brk  = !rx_s && (smp_q.sh == '0)
                                         && (!par_en || !smp_q.pbit);
                        smp_d.st       = rx_s ? RX_IDLE : RX_HOLD;
                    end else begin
                        smp_d.cnt = smp_q.cnt + 1'b1;
                    end
                end
                RX_HOLD: begin
                    if (rx_s) smp_d.st = RX_IDLE;
                end
                default: smp_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q    <= '0;
            smp_q.st <= RX_IDLE;
            smp_q.s1 <= 1'b1;
            smp_q.s2 <= 1'b1;
        end else begin
            smp_q <= smp_d;
        end
    end

    assign frm_valid = smp_q.valid;
    assign frm       = smp_q.frm;

    // R12: a disabled receiver produces no frame in the following cycle
    assert_stop_rx_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !frm_valid);

endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [AW-1:0]    PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

    typedef struct packed {
        logic [AW-1:0]    wp;
        logic [AW-1:0]    rp;
        logic [CNT_W-1:0] cnt;
    } fifo_t;

    fifo_t fifo_d, fifo_q;
    logic [W-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    assign full    = (fifo_q.cnt == CNT_MAX);
    assign empty   = (fifo_q.cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;

    always_comb begin
        fifo_d = fifo_q;
        if (push_ok) fifo_d.wp = (fifo_q.wp == PTR_LAST) ? '0 : fifo_q.wp + 1'b1;
        if (pop_ok)  fifo_d.rp = (fifo_q.rp == PTR_LAST) ? '0 : fifo_q.rp + 1'b1;
        case ({push_ok, pop_ok})
            2'b10:   fifo_d.cnt = fifo_q.cnt + 1'b1;
            2'b01:   fifo_d.cnt = fifo_q.cnt - 1'b1;
            default: fifo_d.cnt = fifo_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fifo_q <= '0;
        else        fifo_q <= fifo_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[fifo_q.wp] <= din;
    end

    assign head  = mem_q[fifo_q.rp];
    assign count = fifo_q.cnt;

    // R2: the count never goes past the depth
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_MAX);

    // R3: popping an empty FIFO leaves the count alone
    assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (count == '0));

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OSR   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       rx_irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic              rx_en;
        logic              par_en;
        logic [1:0]        tsel;
        logic [FL_NUM-1:0] flags;
        logic [FL_NUM-1:0] arm;
        logic              irq;
        logic [BYTE_W-1:0] last;
    } regs_t;

    regs_t regs_d, regs_q;

    logic              frm_valid;
    rx_frame_t         frm;
    logic [BYTE_W-1:0] head;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              fifo_full, fifo_empty;
    logic              ctl_wr, st_rd, st_wr, dat_rd;
    logic [CNT_W-1:0]  trig_lvl;
    logic              unused_wbits;

    function automatic logic [CNT_W-1:0] level_of(input logic [1:0] sel);
        int lv;
        case (sel)
            2'd0:    lv = 1;
            2'd1:    lv = 4;
            2'd2:    lv = 8;
            default: lv = 14;
        endcase
        if (lv > DEPTH) lv = DEPTH;
        return CNT_W'(lv);
    endfunction

    assign ctl_wr       = reg_wr && (reg_addr == 2'd0);
    assign st_wr        = reg_wr && (reg_addr == 2'd1);
    assign st_rd        = reg_rd && (reg_addr == 2'd1);
    assign dat_rd       = reg_rd && (reg_addr == 2'd2);
    assign trig_lvl     = level_of(regs_q.tsel);
    assign unused_wbits = ^reg_wdata[7:6];

    rx_frame_sampler #(.OSR(OSR)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rx_en     (regs_q.rx_en),
        .par_en    (regs_q.par_en),
        .rxd       (rxd),
        .frm_valid (frm_valid),
        .frm       (frm)
    );

    rx_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (frm_valid),
        .din   (frm.data),
        .pop   (dat_rd),
        .head  (head),
        .count (fifo_cnt),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    always_comb begin
        regs_d     = regs_q;
        regs_d.irq = 1'b0;
        if (ctl_wr) begin
            regs_d.rx_en  = reg_wdata[0];
            regs_d.par_en = reg_wdata[1];
            regs_d.tsel   = reg_wdata[3:2];
        end
        if (st_rd) regs_d.arm = regs_q.arm | regs_q.flags;
        if (st_wr) begin
            for (int i = 0; i < FL_NUM; i++) begin
                if (!reg_wdata[i] && regs_q.arm[i]) begin
                    if (i != FL_RDY || fifo_cnt < trig_lvl) regs_d.flags[i] = 1'b0;
                end
            end
            regs_d.arm = '0;
        end
        // setting wins over a clear in the same cycle
        if (fifo_cnt >= trig_lvl) regs_d.flags[FL_RDY] = 1'b1;
        if (frm_valid) begin
            if (frm.perr || frm.ferr) regs_d.flags[FL_ERR] = 1'b1;
            if (frm.perr) regs_d.flags[FL_PAR] = 1'b1;
            if (frm.ferr) regs_d.flags[FL_FRM] = 1'b1;
            if (frm.brk)  regs_d.flags[FL_BRK] = 1'b1;
            if (fifo_full) regs_d.flags[FL_OVR] = 1'b1;
        end
        regs_d.irq = regs_d.flags[FL_RDY] && !regs_q.flags[FL_RDY];
        if (dat_rd && !fifo_empty) regs_d.last = head;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (reg_addr)
            2'd0:    reg_rdata = {4'b0, regs_q.tsel, regs_q.par_en, regs_q.rx_en};
            2'd1:    reg_rdata = {1'b0, rxd, regs_q.flags};
            2'd2:    reg_rdata = fifo_empty ? regs_q.last : head;
            default: reg_rdata = 8'(fifo_cnt);
        endcase
    end

    assign rx_irq = regs_q.irq;

    // R6: the pulse coincides with a fresh data-ready flag
    assert_irq_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (regs_q.flags[FL_RDY] && !$past(regs_q.flags[FL_RDY])));

    // R8: data-ready follows a fill at or above the trigger
    assert_rdy_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt >= trig_lvl) |=> regs_q.flags[FL_RDY]);

    // R7: the error flag only drops after an armed write of 0
    assert_clear_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(regs_q.flags[FL_ERR]) |-> $past(st_wr && regs_q.arm[FL_ERR] && !reg_wdata[FL_ERR]));

    // R4: a frame arriving into a full FIFO raises overrun
    assert_overrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && fifo_full) |=> regs_q.flags[FL_OVR]);

endmodule

// File: tb/uart_rx_status_test.sv
module uart_rx_status_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       rxd = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       rx_irq;

    int total = 0;
    int bad = 0;
    int irq_cnt = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_rx_status uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_irq(rx_irq)
    );

    always @(posedge clk) if (rst_n && rx_irq) irq_cnt <= irq_cnt + 1;

    // {data, parity_en, bad_parity, bad_stop, expected status[6:0]}
    localparam int NV = 7;
    localparam logic [17:0] VEC [NV] = '{
        {8'hA5, 3'b000, 7'h41},   // R1 clean 8N1
        {8'h3C, 3'b100, 7'h41},   // R1 clean 8E1
        {8'h3C, 3'b110, 7'h4B},   // R9 parity error
        {8'h81, 3'b001, 7'h53},   // R10 framing error
        {8'h00, 3'b001, 7'h57},   // R11 break
        {8'hFF, 3'b100, 7'h41},   // R1 8E1 all ones
        {8'h00, 3'b100, 7'h41}    // R11 null byte, not a break
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic hold_bit(input logic v);
        rxd = v;
        repeat (16) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input logic pen, input logic bpar, input logic bstop);
        @(negedge clk);
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(b[i]);
        if (pen) hold_bit((^b) ^ bpar);
        hold_bit(!bstop);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    logic [7:0] d;
    int ic;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(2'd1, d); chk("R11 reset status", d, 8'h40);
        rd(2'd3, d); chk("R2 reset count", d, 0);
        rd(2'd0, d); chk("R12 reset control", d, 0);

        // table walk with trigger level 1
        for (int k = 0; k < NV; k++) begin
            logic [17:0] v;
            v = VEC[k];
            wr(2'd0, {6'b0, v[9], 1'b1});
            ic = irq_cnt;
            send(v[17:10], v[9], v[8], v[7]);
            rd(2'd1, d); chk($sformatf("R9 R10 R11 status vec%0d", k), d, {1'b0, v[6:0]});
            chk($sformatf("R6 irq vec%0d", k), irq_cnt - ic, 1);
            rd(2'd3, d); chk($sformatf("R2 count vec%0d", k), d, 1);
            rd(2'd2, d); chk($sformatf("R1 data vec%0d", k), d, v[17:10]);
            wr(2'd1, 8'h00);
            rd(2'd1, d); chk($sformatf("R7 cleared vec%0d", k), d, 8'h40);
        end

        // R3 empty read
        rd(2'd2, d); chk("R3 empty read value", d, 8'h00);
        rd(2'd3, d); chk("R3 empty read count", d, 0);

        // R7 write 0 without a prior read
        wr(2'd0, 8'h03);
        send(8'h3C, 1'b1, 1'b1, 1'b0);
        wr(2'd1, 8'h00);
        rd(2'd1, d); chk("R7 unarmed write keeps flags", d, 8'h4B);
        rd(2'd2, d);
        wr(2'd1, 8'h00);
        rd(2'd1, d); chk("R7 armed write clears", d, 8'h40);

        // R5 / R8 trigger level 4
        wr(2'd0, 8'h05);
        ic = irq_cnt;
        send(8'h11, 1'b0, 1'b0, 1'b0);
        send(8'h22, 1'b0, 1'b0, 1'b0);
        send(8'h33, 1'b0, 1'b0, 1'b0);
        rd(2'd1, d); chk("R5 below trigger", d, 8'h40);
        chk("R6 no irq below trigger", irq_cnt - ic, 0);
        send(8'h44, 1'b0, 1'b0, 1'b0);
        rd(2'd1, d); chk("R5 at trigger", d, 8'h41);
        chk("R6 irq at trigger", irq_cnt - ic, 1);
        wr(2'd1, 8'h00);
        rd(2'd1, d); chk("R8 clear refused at trigger", d, 8'h41);
        rd(2'd2, d); chk("R2 order 1", d, 8'h11);
        wr(2'd1, 8'h00);
        rd(2'd1, d); chk("R8 clear below trigger", d, 8'h40);
        rd(2'd2, d); chk("R2 order 2", d, 8'h22);
        rd(2'd2, d); chk("R2 order 3", d, 8'h33);
        rd(2'd2, d); chk("R2 order 4", d, 8'h44);

        // R4 overrun with trigger level 14
        wr(2'd0, 8'h0D);
        ic = irq_cnt;
        for (int i = 0; i < 17; i++) send(8'(8'h50 + i), 1'b0, 1'b0, 1'b0);
        chk("R6 irq at 14", irq_cnt - ic, 1);
        rd(2'd3, d); chk("R4 count full", d, 16);
        rd(2'd1, d); chk("R4 overrun flag", d, 8'h61);
        for (int i = 0; i < 16; i++) begin
            rd(2'd2, d); chk($sformatf("R4 kept byte %0d", i), d, 8'h50 + i);
        end
        rd(2'd3, d); chk("R4 dropped byte absent", d, 0);
        wr(2'd1, 8'h00);
        rd(2'd1, d); chk("R7 overrun cleared", d, 8'h40);

        // R12 receiver disabled
        wr(2'd0, 8'h00);
        send(8'h77, 1'b0, 1'b0, 1'b0);
        rd(2'd3, d); chk("R12 disabled count", d, 0);
        rd(2'd1, d); chk("R12 disabled status", d, 8'h40);

        // R11 live line level
        @(negedge clk); rxd = 1'b0;
        rd(2'd1, d); chk("R11 live rxd low", d, 8'h00);
        @(negedge clk); rxd = 1'b1;
        rd(2'd1, d); chk("R11 live rxd high", d, 8'h40);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule